// File: doc/BRIEF.md
# Carry-Save Fermat Transform Butterfly

This block is one radix-2 butterfly element for a number-theoretic transform modulo 2^W+1 whose root of unity is 2. Every operand is held in diminished-one code, where an W-bit vector `v` stands for the residue `v+1`. Each of the two butterfly inputs arrives in carry-save form, as two diminished-one vectors whose residues add up to the operand. The outputs keep that form, so the next stage can take them without any carry ever being resolved.

The second input is scaled by 2^e. In diminished-one code this is a left rotation by `e` in which the bits that wrap from the top to the bottom are inverted. Exponents from W to 2W-1 also invert the whole vector, because 2^W is -1 modulo 2^W+1. The sum output merges the first pair and the scaled second pair in a modulo 2^W+1 4-2 compressor. The difference output inverts the scaled pair bit by bit, which negates a diminished-one value, and feeds it to a second compressor. Each compressor is two carry-save adder rows whose carry vector is rotated left by one with its top bit inverted and wrapped to bit 0. No carry chain runs along any word.

The exponent can come from an input port or be fixed per instance by a parameter. The outputs can pass through one register stage or leave the block without registers. Zero operands, which have no code in this format, are not handled, and neither is resolving a carry-save pair to a single word.

Top module: `fnt_bfly_csave`

## Requirements
- R1: `W` is from 2 to 30. The exponent lies in 0..2W-1, either from `twid_exp` or from the `TW_FIXED` parameter.
- R2: With residue(v) = v+1, (res(`up_s`)+res(`up_c`)) mod 2^W+1 equals (res(`a0_dm`)+res(`a1_dm`)) + 2^e·(res(`b0_dm`)+res(`b1_dm`)) mod 2^W+1.
- R3: (res(`dn_s`)+res(`dn_c`)) mod 2^W+1 equals (res(`a0_dm`)+res(`a1_dm`)) − 2^e·(res(`b0_dm`)+res(`b1_dm`)) mod 2^W+1.
- R4: Every exponent from 0 to 2W-1 is supported. For e < W, the `up_s`/`up_c` vectors at exponent e+W are bit-for-bit equal to the `dn_s`/`dn_c` vectors at exponent e for the same operands.
- R5: With `OUT_REG`=1 (default), the outputs appear one rising clock edge after the inputs and hold until the next edge. An active-low `rst_n`, asynchronous, forces all four outputs to zero.
- R6: With `TW_FIXED` ≥ 0, that value is the exponent and `twid_exp` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a0_dm | input | W | First input, diminished-one vector 0 |
| a1_dm | input | W | First input, diminished-one vector 1 |
| b0_dm | input | W | Second input, diminished-one vector 0 |
| b1_dm | input | W | Second input, diminished-one vector 1 |
| twid_exp | input | EW | Twiddle exponent, EW = clog2(2W) |
| up_s | output | W | Sum output, sum vector |
| up_c | output | W | Sum output, carry vector |
| dn_s | output | W | Difference output, sum vector |
| dn_c | output | W | Difference output, carry vector |

## Verification
The behaviour that is hardest to reach from the ports is the wrap-around of the twiddle for exponents of W and above. There the complement of the rotated pair must match, bit for bit, the difference path at the exponent W lower. The stimulus sweeps every exponent from 0 to 2W-1 and then runs each lower exponent next to its upper partner on the same operands, so the vectors themselves can be compared and not just their resolved residues. Operands that are all zeros and all ones drive the inverted wrap bits and the carry row to their extremes.

// File: rtl/fnt_bfly_pkg.sv
package fnt_bfly_pkg;

   // residue of a carry-save diminished-one pair
   function automatic logic [63:0] pair_res(input logic [63:0] p, input logic [63:0] q,
                                            input logic [63:0] modv);
      return (p + q + 64'd2) % modv;
   endfunction

   // multiply a residue by 2^k
   function automatic logic [63:0] mul_pow2(input logic [63:0] v, input int k,
                                            input logic [63:0] modv);
      logic [63:0] r;
      r = v % modv;
      for (int i = 0; i < k; i++) r = (r * 64'd2) % modv;
      return r;
   endfunction

endpackage

// File: rtl/dm1_csa_row.sv
// One carry-save row of three diminished-one words; top carry wraps inverted.
module dm1_csa_row #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   logic [W-1:0] maj;

   assign s   = x ^ y ^ z;
   assign maj = (x & y) | (x & z) | (y & z);
   assign c   = {maj[W-2:0], ~maj[W-1]};
endmodule

// File: rtl/dm1_cmp42.sv
// Modulo 2^W+1 4-2 compressor built from two carry-save rows.
module dm1_cmp42 #(
   parameter int W = 8
) (
   input  logic [W-1:0] x0,
   input  logic [W-1:0] x1,
   input  logic [W-1:0] x2,
   input  logic [W-1:0] x3,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   logic [W-1:0] s1, c1;

   dm1_csa_row #(.W(W)) i_row0 (.x(x0), .y(x1), .z(x2), .s(s1), .c(c1));
   dm1_csa_row #(.W(W)) i_row1 (.x(s1), .y(c1), .z(x3), .s(s),  .c(c));
endmodule

// File: rtl/dm1_twiddle.sv
// Multiply a diminished-one word by 2^e: rotate left, inverting wrapped bits.
module dm1_twiddle
   import fnt_bfly_pkg::*;
#(
   parameter int W   = 8,
   parameter int FIX = -1,
   parameter int EW  = 4
) (
   input  logic [W-1:0]  x,
   input  logic [EW-1:0] e,
   output logic [W-1:0]  y
);
   localparam logic [63:0] MODV = (64'd1 << W) + 64'd1;
   localparam logic [EW:0] ELIM = (EW+1)'(2 * W);

   logic [3*W-1:0] ext;
   logic [EW-1:0]  eff;

   assign ext = {x, ~x, x};
   assign eff = (FIX >= 0) ? EW'(FIX) : e;

   generate
      if (FIX >= 0) begin : g_fixed
         if (FIX >= 2 * W) begin : g_bad
            $error("dm1_twiddle: FIX out of range");
         end
         assign y = ext[3*W-1-(FIX % (2*W)) -: W];
      end else begin : g_var
         logic [3*W-1:0] sh;
         assign sh = ext << e;
         assign y  = sh[3*W-1 -: W];
      end
   endgenerate

   always_comb begin
      if ({1'b0, eff} < ELIM) begin
         a_r2_twiddle_scale : assert (((64'(y) + 64'd1) % MODV) ==
                                      mul_pow2(64'(x) + 64'd1, int'(eff), MODV))
            else $error("twiddle scale mismatch (R2)");
      end
   end
endmodule

// File: rtl/fnt_bfly_csave.sv
module fnt_bfly_csave
   import fnt_bfly_pkg::*;
#(
   parameter int W        = 8,
   parameter int TW_FIXED = -1,
   parameter bit OUT_REG  = 1'b1,
   localparam int EW      = $clog2(2 * W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  a0_dm,
   input  logic [W-1:0]  a1_dm,
   input  logic [W-1:0]  b0_dm,
   input  logic [W-1:0]  b1_dm,
   input  logic [EW-1:0] twid_exp,
   output logic [W-1:0]  up_s,
   output logic [W-1:0]  up_c,
   output logic [W-1:0]  dn_s,
   output logic [W-1:0]  dn_c
);
   localparam logic [63:0] MODV = (64'd1 << W) + 64'd1;
   localparam logic [EW:0] ELIM = (EW+1)'(2 * W);

   // R1: elaboration checks
   generate
      if (W < 2 || W > 30) begin : g_bad_w
         $error("fnt_bfly_csave: W must be 2..30");
      end
   endgenerate

   logic [W-1:0] b0_tw, b1_tw, b0_ng, b1_ng;
   logic [W-1:0] us, uc, ds, dc;

   dm1_twiddle #(.W(W), .FIX(TW_FIXED), .EW(EW)) i_tw0 (.x(b0_dm), .e(twid_exp), .y(b0_tw));
   dm1_twiddle #(.W(W), .FIX(TW_FIXED), .EW(EW)) i_tw1 (.x(b1_dm), .e(twid_exp), .y(b1_tw));

   // diminished-one negation is bitwise inversion
   assign b0_ng = ~b0_tw;
   assign b1_ng = ~b1_tw;

   dm1_cmp42 #(.W(W)) i_up (.x0(a0_dm), .x1(a1_dm), .x2(b0_tw), .x3(b1_tw), .s(us), .c(uc));
   dm1_cmp42 #(.W(W)) i_dn (.x0(a0_dm), .x1(a1_dm), .x2(b0_ng), .x3(b1_ng), .s(ds), .c(dc));

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               up_s <= '0;
               up_c <= '0;
               dn_s <= '0;
               dn_c <= '0;
            end else begin
               up_s <= us;
               up_c <= uc;
               dn_s <= ds;
               dn_c <= dc;
            end
         end
      end else begin : g_comb
         assign up_s = us;
         assign up_c = uc;
         assign dn_s = ds;
         assign dn_c = dc;
      end
   endgenerate

   // ---------------- assertions ----------------
   logic [EW-1:0] eff_e;
   logic [63:0]   a_res, wb_res, ref_up, ref_dn;

   assign eff_e = (TW_FIXED >= 0) ? EW'(TW_FIXED) : twid_exp;

   always_comb begin
      a_res  = pair_res(64'(a0_dm), 64'(a1_dm), MODV);
      wb_res = mul_pow2(pair_res(64'(b0_dm), 64'(b1_dm), MODV), int'(eff_e), MODV);
      ref_up = (a_res + wb_res) % MODV;
      ref_dn = (a_res + MODV - wb_res) % MODV;
   end

   a_r1_exp_range : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((TW_FIXED >= 0) || ({1'b0, twid_exp} < ELIM)))
      else $error("exponent out of range (R1)");

   a_r2_upper_value : assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, eff_e} < ELIM) |-> (pair_res(64'(us), 64'(uc), MODV) == ref_up))
      else $error("sum pair residue wrong (R2)");

   a_r3_lower_value : assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, eff_e} < ELIM) |-> (pair_res(64'(ds), 64'(dc), MODV) == ref_dn))
      else $error("difference pair residue wrong (R3)");

   a_r3_sum_diff : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (((pair_res(64'(us), 64'(uc), MODV) + pair_res(64'(ds), 64'(dc), MODV)) % MODV)
                == ((a_res * 64'd2) % MODV)))
      else $error("sum plus difference is not twice first input (R3)");
endmodule

// File: tb/test_fnt_bfly_csave.sv
module test_fnt_bfly_csave;
   localparam int W      = 8;
   localparam int EW     = 4;
   localparam int MODV   = 257;
   localparam int FIXE   = 3;
   localparam time TCLK  = 10ns;

   // {exp, a0, a1, b0, b1}
   localparam logic [35:0] VECS [8] = '{
      36'h0_00000000, 36'h1_FFFFFFFF, 36'h7_80808080, 36'h8_0112FE7F,
      36'hF_FF00FF00, 36'h3_A55A3CC3, 36'hC_7F7F7F7F, 36'h5_01020408
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] a0, a1, b0, b1;
   logic [EW-1:0] ex;
   logic [W-1:0] us, uc, ds, dc, fus, fuc, fds, fdc;
   int nchk = 0, nfail = 0;
   bit done = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #(TCLK/2) clk = ~clk;

   fnt_bfly_csave #(.W(W)) i_fnt_bfly_csave (
      .clk(clk), .rst_n(rst_n), .a0_dm(a0), .a1_dm(a1), .b0_dm(b0), .b1_dm(b1),
      .twid_exp(ex), .up_s(us), .up_c(uc), .dn_s(ds), .dn_c(dc));

   fnt_bfly_csave #(.W(W), .TW_FIXED(FIXE)) i_fixed (
      .clk(clk), .rst_n(rst_n), .a0_dm(a0), .a1_dm(a1), .b0_dm(b0), .b1_dm(b1),
      .twid_exp(ex), .up_s(fus), .up_c(fuc), .dn_s(fds), .dn_c(fdc));

   function automatic int res2(input logic [W-1:0] p, input logic [W-1:0] q);
      return (int'(p) + int'(q) + 2) % MODV;
   endfunction

   function automatic int exp_up(input int e);
      int a, b;
      a = res2(a0, a1);
      b = res2(b0, b1);
      for (int i = 0; i < e; i++) b = (b * 2) % MODV;
      return (a + b) % MODV;
   endfunction

   function automatic int exp_dn(input int e);
      int a, b;
      a = res2(a0, a1);
      b = res2(b0, b1);
      for (int i = 0; i < e; i++) b = (b * 2) % MODV;
      return (a + MODV - b) % MODV;
   endfunction

   task automatic check(input string req, input int act, input int expv);
      nchk++;
      if (act != expv) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic rnd_ops();
      seed = seed * 32'd1103515245 + 32'd12345;
      {a0, a1} = seed[31:16];
      seed = seed * 32'd1103515245 + 32'd12345;
      {b0, b1} = seed[31:16];
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      {a0, a1, b0, b1} = 32'h5A5A_A5A5;
      ex = 4'd2;
      repeat (3) @(negedge clk);
      // R5: reset state
      check("R5 reset up_s", int'(us), 0);
      check("R5 reset up_c", int'(uc), 0);
      check("R5 reset dn_s", int'(ds), 0);
      check("R5 reset dn_c", int'(dc), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2, R3, and R6 on the fixed-exponent instance
      for (int i = 0; i < 8; i++) begin
         {ex, a0, a1, b0, b1} = VECS[i];
         step();
         check("R2 table up", res2(us, uc), exp_up(int'(ex)));
         check("R3 table dn", res2(ds, dc), exp_dn(int'(ex)));
         check("R6 fixed up", res2(fus, fuc), exp_up(FIXE));
         check("R6 fixed dn", res2(fds, fdc), exp_dn(FIXE));
      end

      // R5: outputs hold between edges
      begin
         int held;
         held = exp_up(int'(ex));
         {a0, a1, b0, b1} = 32'h1357_9BDF;
         ex = 4'd9;
         #1;
         check("R5 hold before edge", res2(us, uc), held);
         step();
         check("R5 after one edge", res2(us, uc), exp_up(9));
      end

      // R4: full exponent sweep
      for (int e = 0; e < 2 * W; e++) begin
         rnd_ops();
         ex = EW'(e);
         step();
         check("R4 sweep up", res2(us, uc), exp_up(e));
         check("R4 sweep dn", res2(ds, dc), exp_dn(e));
      end

      // R4: exponent e+W on sum path equals exponent e on difference path
      for (int e = 0; e < W; e++) begin
         logic [W-1:0] sv, cv;
         rnd_ops();
         ex = EW'(e);
         step();
         sv = ds;
         cv = dc;
         ex = EW'(e + W);
         step();
         check("R4 swap s", int'(us), int'(sv));
         check("R4 swap c", int'(uc), int'(cv));
      end

      // R6: port ignored by fixed instance for several port values
      for (int e = 0; e < 2 * W; e += 5) begin
         ex = EW'(e);
         step();
         check("R6 port ignored", res2(fus, fuc), exp_up(FIXE));
      end

      // R2/R3: pseudo-random operands
      for (int i = 0; i < 40; i++) begin
         rnd_ops();
         seed = seed * 32'd1103515245 + 32'd12345;
         ex = seed[19:16];
         step();
         check("R2 random up", res2(us, uc), exp_up(int'(ex)));
         check("R3 random dn", res2(ds, dc), exp_dn(int'(ex)));
      end

      // R5: asynchronous reset between edges
      #1 rst_n = 1'b0;
      #1;
      check("R5 async reset up_s", int'(us), 0);
      check("R5 async reset dn_c", int'(dc), 0);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      finish_run();
   end
endmodule